// File: doc/BRIEF.md
# Delay-Line Code-Density Calibrator

This block is the calibration engine that a set of time-to-digital channels share. A tapped delay line quantises the arrival time of an edge into a tap index, but the taps are not equally long. The engine measures their real lengths statistically. It steers a random pulse source into the delay line in place of the measured signal and counts how often each tap index is reported. From those counts it builds the tap-to-fraction lookup table that the channels use. Because the random pulses are uncorrelated with the clock, a tap's share of the hits equals its share of one clock period.

The engine runs once when reset is released, and again each time a full-reset command arrives. It first clears the histogram, then collects a fixed, power-of-two number of hits. It then walks the taps in ascending order and writes one table entry per cycle. Finally, it holds a request to the ring-oscillator frequency counter until that counter reports that the reference has been taken. A busy output covers the whole sequence. A debug port can force the random source onto the line at any time and can read back any histogram bin.

Top module: `dline_calibrator`

## Requirements
- R1: While reset is held, and after a calibration start, `busy` is high. The histogram is cleared, so a debug read of any bin returns 0 before new hits arrive.
- R2: `sel_cal` (1 = random source drives the delay line) equals `busy` OR `dbg_force_cal`.
- R3: While hits are being collected, each cycle with `hit_valid` high adds one to the bin selected by `hit_tap`. In every other phase, `hit_valid` leaves the bins unchanged.
- R4: After exactly 2^LOG2_HITS collected hits, the engine stops collecting. Starting the next cycle, it raises `lut_we` for NTAPS consecutive cycles, with `lut_addr` running 0, 1, ..., NTAPS-1.
- R5: With B_k the count of bin k and C_k the sum of bins 0..k-1, the entry written for tap k is floor((2*C_k + B_k) * 2^FRAC_W / 2^(LOG2_HITS+1)). This is the tap centre as a fraction of one clock period.
- R6: An entry whose value from R5 would reach 2^FRAC_W is written as 2^FRAC_W - 1 (8191 for 13 bits).
- R7: After the last table write, `freq_req` stays high and `busy` stays high until a cycle with `freq_done` high. From the next cycle on, `freq_req` and `busy` are low.
- R8: A `recal_req` pulse in any phase restarts the sequence at the histogram clear. `busy` is high in the next cycle.
- R9: `dbg_hist_data` shows the bin addressed by `dbg_hist_addr` one clock after the address is applied. This works in every phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| recal_req | input | 1 | Full-reset command: restart calibration |
| hit_valid | input | 1 | A delay-line hit is present this cycle |
| hit_tap | input | TAP_W | Encoded tap index of the hit |
| freq_done | input | 1 | Reference frequency measurement finished |
| dbg_force_cal | input | 1 | Debug: force the random source onto the delay line |
| dbg_hist_addr | input | TAP_W | Debug: histogram bin to read |
| busy | output | 1 | Calibration in progress |
| sel_cal | output | 1 | Delay-line input select, 1 = random source |
| lut_we | output | 1 | Lookup-table write strobe |
| lut_addr | output | TAP_W | Lookup-table write address (tap index) |
| lut_data | output | FRAC_W | Fractional value for that tap |
| freq_req | output | 1 | Request a reference frequency measurement |
| dbg_hist_data | output | LOG2_HITS+1 | Debug: bin count, registered |

## Verification
Three hit patterns are used for the table computation, and each catches a different class of error. An even spread over all taps produces a straight ramp, which exposes errors in the scale shift and in the half-bin offset. Putting every hit on one tap gives zero below that tap, mid-scale on it and saturation above it, which separates the cumulative sum from the current bin and exercises the clamp. An uneven, irregular spread catches indexing and accumulation-order faults that a symmetric pattern would hide. A restart in the middle of collection, and hits applied after completion, show whether the histogram is cleared and whether it is properly protected from stray hits.

// File: rtl/dline_cal_pkg.sv
package dline_cal_pkg;
  typedef enum logic [2:0] {
    ST_CLEAR = 3'd0,
    ST_ACCUM = 3'd1,
    ST_WRITE = 3'd2,
    ST_FREQ  = 3'd3,
    ST_DONE  = 3'd4
  } cal_state_e;
endpackage

// File: rtl/dline_cal_hist.sv
module dline_cal_hist #(
  parameter int TAP_W     = 4,
  parameter int LOG2_HITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 acc_en,
  input  logic                 hit_valid,
  input  logic [TAP_W-1:0]     hit_tap,
  input  logic [TAP_W-1:0]     rd_idx,
  input  logic [TAP_W-1:0]     dbg_addr,
  output logic [LOG2_HITS:0]   rd_bin,
  output logic [LOG2_HITS:0]   dbg_data,
  output logic                 last_hit
);
  localparam int NTAPS = 1 << TAP_W;
  localparam int CNT_W = LOG2_HITS + 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'((1 << LOG2_HITS) - 1);

  logic [CNT_W-1:0] bins_q [NTAPS];
  logic [CNT_W-1:0] bins_d [NTAPS];
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             take;
  logic             bin_en;

  assign take     = acc_en & hit_valid;
  assign bin_en   = clr | take;
  assign last_hit = take && (cnt_q == LAST_CNT);
  assign rd_bin   = bins_q[rd_idx];

  always_comb begin
    for (int i = 0; i < NTAPS; i++) begin
      bins_d[i] = clr ? '0 : bins_q[i];
    end
    cnt_d = clr ? '0 : cnt_q;
    if (!clr && take) begin
      bins_d[hit_tap] = bins_q[hit_tap] + 1'b1;
      cnt_d           = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NTAPS; i++) bins_q[i] <= '0;
      cnt_q <= '0;
    end else if (bin_en) begin
      for (int i = 0; i < NTAPS; i++) bins_q[i] <= bins_d[i];
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dbg_data <= '0;
    else        dbg_data <= bins_q[dbg_addr];
  end

  // R1
  hist_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));

  // R4
  hist_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_hit |=> !acc_en);

  // R3
  hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !acc_en) |=> $stable(cnt_q));
endmodule

// File: rtl/dline_cal_integ.sv
module dline_cal_integ #(
  parameter int LOG2_HITS = 8,
  parameter int FRAC_W    = 13
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                step,
  input  logic [LOG2_HITS:0]  bin,
  output logic [FRAC_W-1:0]   frac
);
  localparam int CNT_W  = LOG2_HITS + 1;
  localparam int NUM_W  = CNT_W + 1;
  localparam bit LEFT   = (FRAC_W >= LOG2_HITS + 1);
  localparam int SH_L   = LEFT ? FRAC_W - LOG2_HITS - 1 : 0;
  localparam int SH_R   = LEFT ? 0 : LOG2_HITS + 1 - FRAC_W;
  localparam int WIDE_W = NUM_W + SH_L;
  localparam logic [FRAC_W-1:0] FMAX = {FRAC_W{1'b1}};

  logic [CNT_W-1:0]  cum_q, cum_d;
  logic [NUM_W-1:0]  num;
  logic [WIDE_W-1:0] wide;

  assign num = {cum_q, 1'b0} + NUM_W'(bin);

  generate
    if (LEFT) begin : g_shl
      assign wide = WIDE_W'(num) << SH_L;
    end else begin : g_shr
      assign wide = num >> SH_R;
    end
  endgenerate

  assign frac = (wide > WIDE_W'(FMAX)) ? FMAX : wide[FRAC_W-1:0];

  always_comb begin
    cum_d = cum_q;
    if (start)     cum_d = '0;
    else if (step) cum_d = cum_q + bin;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cum_q <= '0;
    else if (start || step)  cum_q <= cum_d;
  end

  // R5
  cum_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !start) |=> (cum_q >= $past(cum_q)));

  // R5
  cum_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cum_q == '0));
endmodule

// File: rtl/dline_cal_seq.sv
module dline_cal_seq
  import dline_cal_pkg::*;
#(
  parameter int TAP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             recal_req,
  input  logic             last_hit,
  input  logic             freq_done,
  output logic             clr,
  output logic             acc_en,
  output logic             step,
  output logic [TAP_W-1:0] idx,
  output logic             freq_req,
  output logic             busy
);
  localparam logic [TAP_W-1:0] LAST_IDX = {TAP_W{1'b1}};

  cal_state_e       state_q, state_d;
  logic [TAP_W-1:0] idx_q, idx_d;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    case (state_q)
      ST_CLEAR: state_d = ST_ACCUM;
      ST_ACCUM: if (last_hit) begin
                  state_d = ST_WRITE;
                  idx_d   = '0;
                end
      ST_WRITE: begin
                  idx_d = idx_q + 1'b1;
                  if (idx_q == LAST_IDX) state_d = ST_FREQ;
                end
      ST_FREQ:  if (freq_done) state_d = ST_DONE;
      ST_DONE:  state_d = ST_DONE;
      default:  state_d = ST_CLEAR;
    endcase
    if (recal_req) begin
      state_d = ST_CLEAR;
      idx_d   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_CLEAR;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  assign clr      = (state_q == ST_CLEAR);
  assign acc_en   = (state_q == ST_ACCUM);
  assign step     = (state_q == ST_WRITE);
  assign freq_req = (state_q == ST_FREQ);
  assign busy     = (state_q != ST_DONE);
  assign idx      = idx_q;

  // R4
  write_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && idx_q != LAST_IDX && !recal_req) |=> step);

  // R7
  freq_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(freq_req) |-> $past(step));

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (freq_req && freq_done && !recal_req) |=> !busy);

  // R8
  recal_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    recal_req |=> (busy && clr));
endmodule

// File: rtl/dline_calibrator.sv
module dline_calibrator #(
  parameter int TAP_W     = 4,
  parameter int LOG2_HITS = 8,
  parameter int FRAC_W    = 13
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 recal_req,
  input  logic                 hit_valid,
  input  logic [TAP_W-1:0]     hit_tap,
  input  logic                 freq_done,
  input  logic                 dbg_force_cal,
  input  logic [TAP_W-1:0]     dbg_hist_addr,
  output logic                 busy,
  output logic                 sel_cal,
  output logic                 lut_we,
  output logic [TAP_W-1:0]     lut_addr,
  output logic [FRAC_W-1:0]    lut_data,
  output logic                 freq_req,
  output logic [LOG2_HITS:0]   dbg_hist_data
);
  logic             rst_meta, rst_sync_n;
  logic             clr, acc_en, step, last_hit;
  logic [TAP_W-1:0] idx;
  logic [LOG2_HITS:0] cur_bin;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  dline_cal_seq #(.TAP_W(TAP_W)) seq_i (
    .clk(clk), .rst_n(rst_sync_n), .recal_req(recal_req), .last_hit(last_hit),
    .freq_done(freq_done), .clr(clr), .acc_en(acc_en), .step(step), .idx(idx),
    .freq_req(freq_req), .busy(busy)
  );

  dline_cal_hist #(.TAP_W(TAP_W), .LOG2_HITS(LOG2_HITS)) hist_i (
    .clk(clk), .rst_n(rst_sync_n), .clr(clr), .acc_en(acc_en),
    .hit_valid(hit_valid), .hit_tap(hit_tap), .rd_idx(idx),
    .dbg_addr(dbg_hist_addr), .rd_bin(cur_bin), .dbg_data(dbg_hist_data),
    .last_hit(last_hit)
  );

  dline_cal_integ #(.LOG2_HITS(LOG2_HITS), .FRAC_W(FRAC_W)) integ_i (
    .clk(clk), .rst_n(rst_sync_n), .start(clr), .step(step), .bin(cur_bin),
    .frac(lut_data)
  );

  assign sel_cal  = busy | dbg_force_cal;
  assign lut_we   = step;
  assign lut_addr = idx;

  // R2
  sel_busy_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    busy |-> sel_cal);

  // R4
  we_busy_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    lut_we |-> (busy && !freq_req));
endmodule

// File: tb/dline_calibrator_tb_top.sv
module dline_calibrator_tb_top;
  localparam int TAP_W = 4;
  localparam int LOG2_HITS = 8;
  localparam int FRAC_W = 13;
  localparam int NTAPS = 1 << TAP_W;
  localparam int HITS = 1 << LOG2_HITS;
  localparam int FMAX = (1 << FRAC_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic recal_req = 1'b0, hit_valid = 1'b0, freq_done = 1'b0, dbg_force_cal = 1'b0;
  logic [TAP_W-1:0] hit_tap = '0, dbg_hist_addr = '0;
  logic busy, sel_cal, lut_we, freq_req;
  logic [TAP_W-1:0] lut_addr;
  logic [FRAC_W-1:0] lut_data;
  logic [LOG2_HITS:0] dbg_hist_data;

  int checks = 0;
  int errors = 0;
  int model [NTAPS];
  int exp_q [$];
  bit finished = 0;

  always #5 clk = ~clk;

  dline_calibrator #(.TAP_W(TAP_W), .LOG2_HITS(LOG2_HITS), .FRAC_W(FRAC_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .recal_req(recal_req), .hit_valid(hit_valid),
    .hit_tap(hit_tap), .freq_done(freq_done), .dbg_force_cal(dbg_force_cal),
    .dbg_hist_addr(dbg_hist_addr), .busy(busy), .sel_cal(sel_cal), .lut_we(lut_we),
    .lut_addr(lut_addr), .lut_data(lut_data), .freq_req(freq_req),
    .dbg_hist_data(dbg_hist_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int tap_of(input int mode, input int i);
    case (mode)
      0: return i % NTAPS;
      1: return 5;
      default: return (i * i + 3 * i) % 11;
    endcase
  endfunction

  // Scoreboard monitor: every table write is compared with the next expected entry
  always @(negedge clk) begin
    if (rst_n && lut_we) begin
      if (exp_q.size() == 0) begin
        chk(0, "R4 unexpected write", int'(lut_addr), -1);
      end else begin
        int e;
        e = exp_q.pop_front();
        chk(int'(lut_addr) == (e >> 16), "R4 addr", int'(lut_addr), e >> 16);
        if ((e & 16'hffff) == FMAX && (e >> 16) > 0)
          chk(int'(lut_data) == (e & 16'hffff), "R6 saturate", int'(lut_data), e & 16'hffff);
        else
          chk(int'(lut_data) == (e & 16'hffff), "R5 value", int'(lut_data), e & 16'hffff);
      end
    end
  end

  // Driver: builds the reference histogram, queues expected entries, then sends the hits
  task automatic run_cal(input int mode);
    int cum;
    for (int k = 0; k < NTAPS; k++) model[k] = 0;
    for (int i = 0; i < HITS; i++) model[tap_of(mode, i)]++;
    cum = 0;
    for (int k = 0; k < NTAPS; k++) begin
      longint v;
      v = (longint'(2 * cum + model[k]) * (1 << FRAC_W)) / (HITS * 2);
      if (v > FMAX) v = FMAX;
      exp_q.push_back((k << 16) | int'(v));
      cum += model[k];
    end
    for (int i = 0; i < HITS; i++) begin
      @(negedge clk);
      hit_valid = 1'b1;
      hit_tap = TAP_W'(tap_of(mode, i));
    end
    @(negedge clk);
    hit_valid = 1'b0;
    chk(lut_we == 1'b1, "R4 write starts", int'(lut_we), 1);
    while (!freq_req) @(negedge clk);
    chk(exp_q.size() == 0, "R4 all entries", exp_q.size(), 0);
    repeat (3) @(negedge clk);
    chk(busy == 1'b1 && freq_req == 1'b1, "R7 waiting", int'(busy), 1);
    freq_done = 1'b1;
    @(negedge clk);
    freq_done = 1'b0;
    chk(busy == 1'b0, "R7 busy low", int'(busy), 0);
    chk(freq_req == 1'b0, "R7 req low", int'(freq_req), 0);
  endtask

  task automatic read_bin(input int a, input int exp, input string req);
    @(negedge clk);
    dbg_hist_addr = TAP_W'(a);
    @(negedge clk);
    chk(int'(dbg_hist_data) == exp, req, int'(dbg_hist_data), exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 1'b1, "R1 busy in reset", int'(busy), 1);
    chk(lut_we == 1'b0 && freq_req == 1'b0, "R1 idle outputs", int'(lut_we), 0);
    chk(sel_cal == 1'b1, "R2 sel in reset", int'(sel_cal), 1);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    read_bin(3, 0, "R1 cleared bin");

    // Even spread
    run_cal(0);
    for (int k = 0; k < NTAPS; k++) read_bin(k, model[k], "R9 readback");

    // Hits after completion are ignored
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      hit_valid = 1'b1;
      hit_tap = 4'd2;
    end
    @(negedge clk);
    hit_valid = 1'b0;
    read_bin(2, model[2], "R3 ignored when done");
    chk(busy == 1'b0, "R3 still done", int'(busy), 0);

    // Forced source select
    chk(sel_cal == 1'b0, "R2 sel idle", int'(sel_cal), 0);
    dbg_force_cal = 1'b1;
    @(negedge clk);
    chk(sel_cal == 1'b1, "R2 sel forced", int'(sel_cal), 1);
    dbg_force_cal = 1'b0;
    @(negedge clk);
    chk(sel_cal == 1'b0, "R2 sel released", int'(sel_cal), 0);

    // Restart from done, then restart again during collection
    recal_req = 1'b1;
    @(negedge clk);
    recal_req = 1'b0;
    chk(busy == 1'b1, "R8 busy after recal", int'(busy), 1);
    chk(sel_cal == 1'b1, "R2 sel while busy", int'(sel_cal), 1);
    @(negedge clk);
    read_bin(0, 0, "R1 bin cleared after recal");
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      hit_valid = 1'b1;
      hit_tap = 4'd3;
    end
    @(negedge clk);
    hit_valid = 1'b0;
    read_bin(3, 10, "R3 counted hits");
    @(negedge clk);
    recal_req = 1'b1;
    @(negedge clk);
    recal_req = 1'b0;
    chk(busy == 1'b1, "R8 busy mid-run", int'(busy), 1);
    @(negedge clk);
    read_bin(3, 0, "R8 bin cleared mid-run");

    // All hits on one tap
    run_cal(1);
    // Irregular spread
    @(negedge clk);
    recal_req = 1'b1;
    @(negedge clk);
    recal_req = 1'b0;
    repeat (2) @(negedge clk);
    run_cal(2);
    read_bin(7, model[7], "R9 readback irregular");

    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule